// File: doc/BRIEF.md
# SPI Slave Register-Access Front End

This block is a serial-peripheral slave that runs entirely in the system clock domain. It resynchronises the serial clock, the active-low select and the serial data-in line. From these it finds the serial clock edges, shifts in a command byte and decodes it.

For register traffic, the command byte carries a 6-bit address. The byte that follows either loads an 8-bit register or returns that register's value on the serial data-out line. The register file has 64 entries. Core logic reaches the same storage through a second, fully parallel port. Commands aimed at the frame buffer or at SRAM are only classified: the class is reported on a mode output for other logic to act on.

Transfers use SPI mode 0, most significant bit first. Each transfer is framed by select going low and ends when select returns high. Raising select early abandons the transfer.

Top module: `spi_reg_frontend`

## Requirements
- R1: Serial data-in is sampled on each rising serial clock edge while select is low, most significant bit first; the first eight bits form the command byte.
- R2: A command with bits [7:6] = 2'b10 is a register read of address bits [5:0]; that register's value appears on serial data-out during the second byte, most significant bit first, each bit updated after a falling serial clock edge.
- R3: A command with bits [7:6] = 2'b11 is a register write of address bits [5:0]; the complete second byte is stored there after its eighth rising edge.
- R4: After the command byte, mode_o holds 1 for register read, 2 for register write, 3 for frame-buffer read (bits [7:5] = 3'b001), 4 for frame-buffer write (3'b011), 5 for SRAM read (3'b000) and 6 for SRAM write (3'b010); it returns to 0 once select is high.
- R5: Serial data-in during the data byte of a register read is ignored: the register keeps its value.
- R6: Select going high mid-transfer abandons it: a partly received write byte is never stored, and the next transfer starts with a fresh command byte.
- R7: While select is high, spi_miso_oe is 0 and spi_miso is 0; while a transfer is in progress, spi_miso_oe is 1.
- R8: The core port writes core_wdata at core_addr when core_we is 1, and core_rdata returns the value at core_addr one clock later, including values stored over the serial port.
- R9: spi_miso is 0 throughout the command byte.
- R10: After reset, mode_o, spi_miso and spi_miso_oe are all 0.
- R11: Bytes after the second byte of a transfer are ignored; frame-buffer and SRAM commands never write a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from master |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| mode_o | output | 3 | Decoded command class |
| core_addr | input | 6 | Core-side register address |
| core_we | input | 1 | Core-side write strobe |
| core_wdata | input | 8 | Core-side write data |
| core_rdata | output | 8 | Core-side read data, registered |

## Verification
Some properties are checked on every clock cycle. The output enable and data-out both collapse once select is idle. Data-out only changes after a detected falling edge or a deselect. A register write only follows a detected rising edge inside a transfer. mode_o clears after deselect and never takes the unused code.

Other behaviours only show up in the bench's transfers: the value returned for a given address, which byte actually lands in storage, and the effect of abandoned transfers and trailing bytes. Those scenarios also cover the reserved-address commands that must leave registers untouched, and the agreement between the serial port and the core port.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef enum logic [2:0] {
    MODE_NONE  = 3'd0,
    MODE_REG_RD = 3'd1,
    MODE_REG_WR = 3'd2,
    MODE_FB_RD  = 3'd3,
    MODE_FB_WR  = 3'd4,
    MODE_SR_RD  = 3'd5,
    MODE_SR_WR  = 3'd6
  } acc_mode_t;

  function automatic acc_mode_t decode_cmd(input logic [7:0] b);
    if (b[7]) begin
      return b[6] ? MODE_REG_WR : MODE_REG_RD;
    end
    case ({b[6], b[5]})
      2'b00:   return MODE_SR_RD;
      2'b01:   return MODE_FB_RD;
      2'b10:   return MODE_SR_WR;
      default: return MODE_FB_WR;
    endcase
  endfunction
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_idle,
  output logic mosi_s
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sclk_q, cs_q, mosi_q;
  logic         sclk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= '0;
      cs_q      <= '1;
      mosi_q    <= '0;
      sclk_last <= 1'b0;
    end else begin
      sclk_q    <= {sclk_q[TOP-1:0], sclk_in};
      cs_q      <= {cs_q[TOP-1:0], cs_n_in};
      mosi_q    <= {mosi_q[TOP-1:0], mosi_in};
      sclk_last <= sclk_q[TOP];
    end
  end

  assign sclk_rise = sclk_q[TOP] & ~sclk_last;
  assign sclk_fall = ~sclk_q[TOP] & sclk_last;
  assign cs_idle   = cs_q[TOP];
  assign mosi_s    = mosi_q[TOP];
endmodule

// File: rtl/spi_fe_regfile.sv
module spi_fe_regfile #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) begin
      mem[a_addr] <= a_wdata;
    end else if (b_we) begin
      mem[b_addr] <= b_wdata;
    end
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/spi_fe_engine.sv
module spi_fe_engine
  import spi_fe_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sclk_rise,
  input  logic           sclk_fall,
  input  logic           cs_idle,
  input  logic           mosi_s,
  output logic [DW-3:0]  ram_addr,
  output logic           ram_we,
  output logic [DW-1:0]  ram_wdata,
  input  logic [DW-1:0]  ram_rdata,
  output logic           miso,
  output logic           miso_oe,
  output acc_mode_t      mode
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_DONE} phase_t;

  phase_t        phase;
  logic [CW-1:0] bit_cnt;
  logic [DW-2:0] shreg;
  logic [DW-1:0] tx;
  logic [1:0]    load_pend;
  logic [DW-1:0] in_byte;

  assign in_byte = {shreg, mosi_s};

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      phase     <= PH_CMD;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx        <= '0;
      load_pend <= '0;
      ram_we    <= 1'b0;
      miso      <= 1'b0;
      mode      <= MODE_NONE;
      if (rst) begin
        ram_addr  <= '0;
        ram_wdata <= '0;
      end
    end else begin
      ram_we    <= 1'b0;
      load_pend <= {load_pend[0], 1'b0};
      if (load_pend[1]) begin
        tx <= ram_rdata;
      end
      if (sclk_rise) begin
        shreg   <= in_byte[DW-2:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          case (phase)
            PH_CMD: begin
              mode     <= decode_cmd(in_byte);
              ram_addr <= in_byte[DW-3:0];
              phase    <= PH_DATA;
              if (in_byte[DW-1 -: 2] == 2'b10) begin
                load_pend <= {load_pend[0], 1'b1};
              end
            end
            PH_DATA: begin
              phase <= PH_DONE;
              if (mode == MODE_REG_WR) begin
                ram_we    <= 1'b1;
                ram_wdata <= in_byte;
              end
            end
            default: phase <= PH_DONE;
          endcase
        end
      end
      if (sclk_fall) begin
        if (phase == PH_DATA && mode == MODE_REG_RD) begin
          miso <= tx[DW-1];
          tx   <= {tx[DW-2:0], 1'b0};
        end else begin
          miso <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= ~cs_idle;
    end
  end
endmodule

// File: rtl/spi_reg_frontend.sv
module spi_reg_frontend
  import spi_fe_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         spi_sclk,
  input  logic         spi_cs_n,
  input  logic         spi_mosi,
  output logic         spi_miso,
  output logic         spi_miso_oe,
  output logic [2:0]   mode_o,
  input  logic [5:0]   core_addr,
  input  logic         core_we,
  input  logic [7:0]   core_wdata,
  output logic [7:0]   core_rdata
);
  localparam int AW = DW - 2;

  logic          sclk_rise, sclk_fall, cs_idle, mosi_s;
  logic [AW-1:0] ram_addr;
  logic          ram_we;
  logic [DW-1:0] ram_wdata, ram_rdata;
  acc_mode_t     mode;

  spi_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .sclk_in   (spi_sclk),
    .cs_n_in   (spi_cs_n),
    .mosi_in   (spi_mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_idle   (cs_idle),
    .mosi_s    (mosi_s)
  );

  spi_fe_engine #(.DW(DW)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_idle   (cs_idle),
    .mosi_s    (mosi_s),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe),
    .mode      (mode)
  );

  spi_fe_regfile #(.AW(AW), .DW(DW)) u_rf (
    .clk     (clk),
    .a_addr  (ram_addr),
    .a_we    (ram_we),
    .a_wdata (ram_wdata),
    .a_rdata (ram_rdata),
    .b_addr  (core_addr),
    .b_we    (core_we),
    .b_wdata (core_wdata),
    .b_rdata (core_rdata)
  );

  assign mode_o = mode;
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker (
  input logic       clk,
  input logic       rst,
  input logic       spi_miso,
  input logic       spi_miso_oe,
  input logic [2:0] mode_o,
  input logic       cs_idle,
  input logic       sclk_rise,
  input logic       sclk_fall,
  input logic       ram_we
);
  // R7
  oe_off_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_idle) |-> !spi_miso_oe);

  // R7
  miso_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !spi_miso_oe |-> !spi_miso);

  // R2
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_miso) |-> ($past(sclk_fall) || $past(cs_idle)));

  // R3
  write_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ($past(sclk_rise) && !$past(cs_idle)));

  // R4
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_idle) |-> (mode_o == 3'd0));

  // R4
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o != 3'd7);
endmodule

bind spi_reg_frontend spi_fe_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .spi_miso    (spi_miso),
  .spi_miso_oe (spi_miso_oe),
  .mode_o      (mode_o),
  .cs_idle     (cs_idle),
  .sclk_rise   (sclk_rise),
  .sclk_fall   (sclk_fall),
  .ram_we      (ram_we)
);

// File: tb/sim_spi_reg_frontend.sv
`timescale 1ns/1ps
module sim_spi_reg_frontend;
  localparam int H = 8;
  localparam int NV = 10;
  // {cmd, data, expected read byte, expected mode}
  localparam logic [31:0] VEC [NV] = '{
    {8'hFF, 8'hA5, 8'h00, 8'd2},
    {8'hBF, 8'h00, 8'hA5, 8'd1},
    {8'hC0, 8'h5A, 8'h00, 8'd2},
    {8'h80, 8'hFF, 8'h5A, 8'd1},
    {8'h95, 8'h00, 8'h3C, 8'd1},
    {8'h20, 8'h00, 8'h00, 8'd3},
    {8'h65, 8'hEE, 8'h00, 8'd4},
    {8'h05, 8'h00, 8'h00, 8'd5},
    {8'h45, 8'hEE, 8'h00, 8'd6},
    {8'h85, 8'h00, 8'h11, 8'd1}
  };

  logic clk = 0, rst = 1;
  logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0;
  logic spi_miso, spi_miso_oe;
  logic [2:0] mode_o;
  logic [5:0] core_addr = 0;
  logic core_we = 0;
  logic [7:0] core_wdata = 0, core_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_reg_frontend u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic core_write(input logic [5:0] a, input logic [7:0] d);
    core_addr = a; core_wdata = d; core_we = 1;
    wclk(1);
    core_we = 0;
  endtask

  task automatic core_read(input logic [5:0] a, output logic [7:0] d);
    core_addr = a;
    wclk(2);
    d = core_rdata;
  endtask

  // Shifts nbits from {b0,b1,b2}; returns second-byte MISO, command-phase MISO, mode, oe
  task automatic spi_txn(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input int nbits, output logic [7:0] rx, output logic [7:0] cmd_rx,
                         output logic [2:0] md, output logic oe);
    logic [23:0] bits;
    bits = {b0, b1, b2};
    rx = 0; cmd_rx = 0; md = 0; oe = 0;
    spi_cs_n = 0;
    wclk(H);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = bits[23 - i];
      wclk(H);
      if (i < 8) cmd_rx = {cmd_rx[6:0], spi_miso};
      else if (i < 16) rx = {rx[6:0], spi_miso};
      if (i == 3) oe = spi_miso_oe;
      if (i == 8) md = mode_o;
      spi_sclk = 1;
      wclk(H);
      spi_sclk = 0;
    end
    wclk(H);
    spi_cs_n = 1;
    wclk(8);
  endtask

  initial begin
    logic [7:0] rx, crx, d;
    logic [2:0] md;
    logic oe;
    wclk(4);
    // R10 reset state
    chk("R10 mode", {5'd0, mode_o}, 8'd0);
    chk("R10 miso", {7'd0, spi_miso}, 8'd0);
    chk("R10 oe", {7'd0, spi_miso_oe}, 8'd0);
    rst = 0;
    wclk(4);
    // R8 core port preload and readback
    core_write(6'h15, 8'h3C);
    core_write(6'h05, 8'h11);
    core_read(6'h15, d);
    chk("R8 core readback", d, 8'h3C);

    for (int v = 0; v < NV; v++) begin
      spi_txn(VEC[v][31:24], VEC[v][23:16], 8'h00, 16, rx, crx, md, oe);
      chk("R4 mode", {5'd0, md}, VEC[v][7:0]);
      chk("R9 miso in cmd", crx, 8'h00);
      chk("R7 oe active", {7'd0, oe}, 8'd1);
      if (VEC[v][7:0] == 8'd1) chk("R2 read data R1", rx, VEC[v][15:8]);
    end
    chk("R4 mode cleared", {5'd0, mode_o}, 8'd0);
    chk("R7 oe idle", {7'd0, spi_miso_oe}, 8'd0);

    // R3 / R8: serial writes visible on core port
    core_read(6'h3F, d);
    chk("R3 write 3F", d, 8'hA5);
    // R5: read with all-ones MOSI left register 0 unchanged
    core_read(6'h00, d);
    chk("R5 read ignores mosi", d, 8'h5A);
    // R11: frame-buffer/SRAM writes with low bits 5 did not touch register 5
    core_read(6'h05, d);
    chk("R11 no reg write", d, 8'h11);

    // R6: abort a write after 4 data bits
    spi_txn(8'hC7, 8'h99, 8'h00, 12, rx, crx, md, oe);
    core_read(6'h07, d);
    core_write(6'h07, 8'h42);
    spi_txn(8'hC7, 8'h99, 8'h00, 12, rx, crx, md, oe);
    core_read(6'h07, d);
    chk("R6 partial write dropped", d, 8'h42);
    // R6: abort within command byte, then a fresh read
    spi_txn(8'hC7, 8'h00, 8'h00, 3, rx, crx, md, oe);
    spi_txn(8'h87, 8'h00, 8'h00, 16, rx, crx, md, oe);
    chk("R6 fresh command read", rx, 8'h42);

    // R11: third byte ignored
    spi_txn(8'hCA, 8'h77, 8'h33, 24, rx, crx, md, oe);
    core_read(6'h0A, d);
    chk("R11 third byte ignored", d, 8'h77);
    // R1: MSB-first sampling, asymmetric pattern
    spi_txn(8'hCB, 8'h81, 8'h00, 16, rx, crx, md, oe);
    core_read(6'h0B, d);
    chk("R1 msb first", d, 8'h81);
    spi_txn(8'h8B, 8'h00, 8'h00, 16, rx, crx, md, oe);
    chk("R2 read back 81", rx, 8'h81);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule